// File: doc/BRIEF.md
# Character Pattern Address and Pixel Shifter

This block turns a latched character code into pixels. It takes the glyph bits of the code and the current row of the character cell (0 to 7), and combines them into an address in the character ROM. It drives that address while the bus is in a refresh cycle, captures the ROM byte that comes back, and then shifts the byte out one pixel per clock. The top bit of the code is an invert flag. It travels with the pattern and flips every pixel of that character.

The row counter advances once per horizontal sync event and returns to zero on vertical sync. A fetched pattern waits in a one-entry holding register until the shifter has sent all eight pixels of the previous character. A stream of characters therefore comes out with no gap between them.

Top module: `chpix_char_shifter`

## Requirements
- R1: While reset is held and right after it, `video_o` is 0 and `rom_addr_o` is 0.
- R2: A code is captured on every clock edge where `code_valid_i` is 1. A later capture replaces an earlier one that has not yet been fetched, and marks a fetch as pending.
- R3: While `rfsh_i` is 1 and a fetch is pending, `rom_addr_o` equals {code[5:0], row[2:0]}, with the code bits in the high part and the row in bits 2:0. Code bit 6 has no effect on the address. At all other times `rom_addr_o` is 0.
- R4: Each clock edge with `hsync_i` at 1 moves the row up by one, and row 7 wraps to 0.
- R5: A clock edge with `vsync_i` at 1 sets the row to 0. This takes priority over `hsync_i` on the same edge.
- R6: The ROM byte is taken on the last edge of the refresh cycle, so the value present in its final cycle is the one used. The pattern becomes ready on the edge where `rfsh_i` is first seen low, and the pending fetch is cleared. A refresh cycle with no pending fetch drives address 0 and loads nothing.
- R7: A ready pattern enters the shifter on a clock edge. From the next cycle, `video_o` shows its 8 bits one per clock, bit 7 first.
- R8: If code bit 7 was 1 when the pattern became ready, all 8 pixels of that character are inverted.
- R9: `video_o` is 0 whenever no pattern bits remain in the shifter.
- R10: A pattern that becomes ready while another is still shifting waits. It is loaded on the edge that ends the last pixel of the current character, so it follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| code_i | input | 8 | Character code: glyph bits 5:0, bit 7 is the invert flag |
| code_valid_i | input | 1 | Strobe that captures `code_i` |
| hsync_i | input | 1 | Horizontal sync event, one clock wide |
| vsync_i | input | 1 | Vertical sync event, one clock wide |
| rfsh_i | input | 1 | High during a bus refresh cycle |
| rom_data_i | input | 8 | Pattern byte returned by the character ROM |
| rom_addr_o | output | 9 | Pattern address into the character ROM |
| video_o | output | 1 | Serial pixel output |

## Verification
`rom_addr_o` is combinational from `rfsh_i` and registered state, so it is due in the same cycle that `rfsh_i` rises. `video_o` shows the first pixel of a character two edges after `rfsh_i` falls: one edge makes the pattern ready and the next loads the shifter. Each further pixel follows one edge later. The bench updates a queue-based model at each rising edge from the inputs present before that edge, and compares both outputs at the falling edge that follows, so every result is checked in the cycle it is due. Stimulus changes just after a falling edge and never at a rising edge.

// File: rtl/chpix_pkg.sv
package chpix_pkg;
   localparam int unsigned DEF_CODE_W     = 8;
   localparam int unsigned DEF_GLYPH_BITS = 6;
   localparam int unsigned DEF_ROWS       = 8;
   localparam int unsigned DEF_PIX_W      = 8;

   typedef enum logic {
      SHIFT_LSB_FIRST = 1'b0,
      SHIFT_MSB_FIRST = 1'b1
   } shift_order_e;
endpackage

// File: rtl/chpix_row_ctr.sv
module chpix_row_ctr #(
   parameter int unsigned ROWS  = 8,
   parameter int unsigned ROW_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             hsync_i,
   input  logic             vsync_i,
   output logic [ROW_W-1:0] row_o
);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         row_o <= '0;
      end else if (vsync_i) begin
         row_o <= '0;
      end else if (hsync_i) begin
         row_o <= (row_o == LAST_ROW) ? '0 : row_o + 1'b1;
      end
   end
endmodule

// File: rtl/chpix_fetch.sv
module chpix_fetch #(
   parameter int unsigned CODE_W     = 8,
   parameter int unsigned GLYPH_BITS = 6,
   parameter int unsigned ROW_W      = 3,
   parameter int unsigned PIX_W      = 8,
   parameter int unsigned ADDR_W     = 9
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              code_valid_i,
   input  logic [ROW_W-1:0]  row_i,
   input  logic              rfsh_i,
   input  logic [PIX_W-1:0]  rom_data_i,
   input  logic              take_i,
   output logic [ADDR_W-1:0] rom_addr_o,
   output logic [PIX_W-1:0]  pat_o,
   output logic              pat_inv_o,
   output logic              pat_full_o
);
   logic [GLYPH_BITS-1:0] glyph_q;
   logic                  inv_flag_q;
   logic                  pend_q;
   logic                  rfsh_q;
   logic [PIX_W-1:0]      cap_q;
   logic                  fill_w;

   generate
      if (GLYPH_BITS < CODE_W - 1) begin : g_spare_bits
         logic code_unused_w;
         assign code_unused_w = ^code_i[CODE_W-2:GLYPH_BITS];
      end
   endgenerate

   assign rom_addr_o = (rfsh_i && pend_q) ? {glyph_q, row_i} : '0;
   assign fill_w     = rfsh_q && !rfsh_i && pend_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         glyph_q    <= '0;
         inv_flag_q <= 1'b0;
         pend_q     <= 1'b0;
         rfsh_q     <= 1'b0;
         cap_q      <= '0;
         pat_o      <= '0;
         pat_inv_o  <= 1'b0;
         pat_full_o <= 1'b0;
      end else begin
         rfsh_q <= rfsh_i;
         if (rfsh_i && pend_q) begin
            cap_q <= rom_data_i;
         end
         if (code_valid_i) begin
            glyph_q    <= code_i[GLYPH_BITS-1:0];
            inv_flag_q <= code_i[CODE_W-1];
            pend_q     <= 1'b1;
         end else if (fill_w) begin
            pend_q <= 1'b0;
         end
         if (fill_w) begin
            pat_o      <= cap_q;
            pat_inv_o  <= inv_flag_q;
            pat_full_o <= 1'b1;
         end else if (take_i) begin
            pat_full_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/chpix_shift.sv
module chpix_shift
   import chpix_pkg::*;
#(
   parameter int unsigned  PIX_W = 8,
   parameter int unsigned  CNT_W = 4,
   parameter shift_order_e ORDER = SHIFT_MSB_FIRST
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [PIX_W-1:0] pat_i,
   input  logic             inv_i,
   input  logic             full_i,
   output logic             take_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             video_o
);
   logic [PIX_W-1:0] sh_q;
   logic             inv_q;
   logic             out_bit_w;
   logic [PIX_W-1:0] sh_next_w;

   generate
      if (ORDER == SHIFT_MSB_FIRST) begin : g_msb
         assign out_bit_w = sh_q[PIX_W-1];
         assign sh_next_w = {sh_q[PIX_W-2:0], 1'b0};
      end else begin : g_lsb
         assign out_bit_w = sh_q[0];
         assign sh_next_w = {1'b0, sh_q[PIX_W-1:1]};
      end
   endgenerate

   assign take_o  = full_i && (cnt_o <= CNT_W'(1));
   assign video_o = (cnt_o != '0) && (out_bit_w ^ inv_q);

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         sh_q  <= '0;
         inv_q <= 1'b0;
         cnt_o <= '0;
      end else if (take_o) begin
         sh_q  <= pat_i;
         inv_q <= inv_i;
         cnt_o <= CNT_W'(PIX_W);
      end else if (cnt_o != '0) begin
         sh_q  <= sh_next_w;
         cnt_o <= cnt_o - 1'b1;
      end
   end
endmodule

// File: rtl/chpix_char_shifter.sv
module chpix_char_shifter
   import chpix_pkg::*;
#(
   parameter int unsigned  CODE_W     = DEF_CODE_W,
   parameter int unsigned  GLYPH_BITS = DEF_GLYPH_BITS,
   parameter int unsigned  ROWS       = DEF_ROWS,
   parameter int unsigned  PIX_W      = DEF_PIX_W,
   parameter shift_order_e ORDER      = SHIFT_MSB_FIRST,
   localparam int unsigned ROW_W      = $clog2(ROWS),
   localparam int unsigned ADDR_W     = GLYPH_BITS + ROW_W
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              code_valid_i,
   input  logic              hsync_i,
   input  logic              vsync_i,
   input  logic              rfsh_i,
   input  logic [PIX_W-1:0]  rom_data_i,
   output logic [ADDR_W-1:0] rom_addr_o,
   output logic              video_o
);
   localparam int unsigned CNT_W = $clog2(PIX_W + 1);

   generate
      if (GLYPH_BITS > CODE_W - 1) begin : g_bad_glyph
         $error("GLYPH_BITS must leave the top code bit for the invert flag");
      end
      if (ROWS < 2) begin : g_bad_rows
         $error("ROWS must be at least 2");
      end
      if (PIX_W < 2) begin : g_bad_pix
         $error("PIX_W must be at least 2");
      end
   endgenerate

   logic [ROW_W-1:0] row_w;
   logic [PIX_W-1:0] pat_w;
   logic             pat_inv_w;
   logic             pat_full_w;
   logic             take_w;
   logic [CNT_W-1:0] shift_cnt_w;

   chpix_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_row (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .hsync_i (hsync_i),
      .vsync_i (vsync_i),
      .row_o   (row_w)
   );

   chpix_fetch #(
      .CODE_W(CODE_W), .GLYPH_BITS(GLYPH_BITS), .ROW_W(ROW_W),
      .PIX_W(PIX_W), .ADDR_W(ADDR_W)
   ) u_fetch (
      .clk_i        (clk_i),
      .rst_n_i      (rst_n_i),
      .code_i       (code_i),
      .code_valid_i (code_valid_i),
      .row_i        (row_w),
      .rfsh_i       (rfsh_i),
      .rom_data_i   (rom_data_i),
      .take_i       (take_w),
      .rom_addr_o   (rom_addr_o),
      .pat_o        (pat_w),
      .pat_inv_o    (pat_inv_w),
      .pat_full_o   (pat_full_w)
   );

   chpix_shift #(.PIX_W(PIX_W), .CNT_W(CNT_W), .ORDER(ORDER)) u_shift (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .pat_i   (pat_w),
      .inv_i   (pat_inv_w),
      .full_i  (pat_full_w),
      .take_o  (take_w),
      .cnt_o   (shift_cnt_w),
      .video_o (video_o)
   );
endmodule

// File: rtl/chpix_char_shifter_chk.sv
module chpix_char_shifter_chk #(
   parameter int unsigned ROWS   = 8,
   parameter int unsigned ROW_W  = 3,
   parameter int unsigned PIX_W  = 8,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned ADDR_W = 9
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic              hsync_i,
   input logic              vsync_i,
   input logic              rfsh_i,
   input logic [ADDR_W-1:0] rom_addr_i,
   input logic              video_i,
   input logic [ROW_W-1:0]  row_i,
   input logic [CNT_W-1:0]  cnt_i,
   input logic              full_i
);
   p_vsync_clears_row_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      vsync_i |=> (row_i == '0));

   p_hsync_steps_row_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (hsync_i && !vsync_i) |=>
         (int'(row_i) == ((int'($past(row_i)) == int'(ROWS) - 1) ? 0 : int'($past(row_i)) + 1)));

   p_addr_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !rfsh_i |-> (rom_addr_i == '0));

   p_blank_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (cnt_i == '0) |-> !video_i);

   p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      int'(cnt_i) <= int'(PIX_W));

   p_wait_for_shift_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (full_i && int'(cnt_i) > 1) |=> full_i);
endmodule

bind chpix_char_shifter chpix_char_shifter_chk #(
   .ROWS(ROWS), .ROW_W(ROW_W), .PIX_W(PIX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_n_i    (rst_n_i),
   .hsync_i    (hsync_i),
   .vsync_i    (vsync_i),
   .rfsh_i     (rfsh_i),
   .rom_addr_i (rom_addr_o),
   .video_i    (video_o),
   .row_i      (row_w),
   .cnt_i      (shift_cnt_w),
   .full_i     (pat_full_w)
);

// File: tb/chpix_char_shifter_tb_top.sv
module chpix_char_shifter_tb_top;
   localparam int ROWS = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] code;
   logic       code_valid;
   logic       hsync;
   logic       vsync;
   logic       rfsh;
   logic [7:0] rom_data;
   logic [8:0] rom_addr;
   logic       video;

   int    n_chk  = 0;
   int    n_fail = 0;
   string cur_tag = "R1";
   bit    cmp_en = 1'b0;
   bit    done   = 1'b0;

   always #5 clk = ~clk;

   function automatic logic [7:0] rom_fn(input logic [8:0] a);
      int t;
      t = int'(a) * 37 + (int'(a) >> 4);
      return 8'(t) ^ 8'hA5;
   endfunction

   assign rom_data = rom_fn(rom_addr);

   chpix_char_shifter dut_i (
      .clk_i        (clk),
      .rst_n_i      (rst_n),
      .code_i       (code),
      .code_valid_i (code_valid),
      .hsync_i      (hsync),
      .vsync_i      (vsync),
      .rfsh_i       (rfsh),
      .rom_data_i   (rom_data),
      .rom_addr_o   (rom_addr),
      .video_o      (video)
   );

   // behavioural reference model
   int         m_row;
   logic [7:0] m_code;
   bit         m_pend, m_prev_rfsh, m_full, m_inv;
   logic [7:0] m_cap, m_buf;
   bit         m_q[$];

   function automatic logic [8:0] model_addr();
      if (rfsh && m_pend) return {m_code[5:0], 3'(m_row)};
      return 9'd0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_row = 0; m_code = '0; m_pend = 0; m_prev_rfsh = 0;
         m_full = 0; m_inv = 0; m_cap = '0; m_buf = '0;
         m_q.delete();
      end else begin
         if (m_q.size() <= 1 && m_full) begin
            m_q.delete();
            for (int i = 7; i >= 0; i--) m_q.push_back(m_buf[i] ^ m_inv);
            m_full = 0;
         end else if (m_q.size() > 0) begin
            void'(m_q.pop_front());
         end
         if (rfsh && m_pend) m_cap = rom_fn(model_addr());
         if (m_prev_rfsh && !rfsh && m_pend) begin
            m_buf = m_cap; m_inv = m_code[7]; m_full = 1; m_pend = 0;
         end
         m_prev_rfsh = rfsh;
         if (code_valid) begin m_code = code; m_pend = 1; end
         if (vsync) m_row = 0;
         else if (hsync) m_row = (m_row + 1) % ROWS;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_en && rst_n && !done) begin
         check({cur_tag, " rom_addr_o"}, int'(rom_addr), int'(model_addr()));
         check({cur_tag, " video_o"}, int'(video), (m_q.size() > 0) ? int'(m_q[0]) : 0);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic put_code(input logic [7:0] c);
      code = c; code_valid = 1'b1; tick(1); code_valid = 1'b0;
   endtask

   task automatic refresh(input int len);
      rfsh = 1'b1; tick(len); rfsh = 1'b0;
   endtask

   task automatic fetch_char(input logic [7:0] c);
      put_code(c); tick(1); refresh(2);
   endtask

   task automatic pulse_h();
      hsync = 1'b1; tick(1); hsync = 1'b0;
   endtask

   task automatic pulse_v();
      vsync = 1'b1; tick(1); vsync = 1'b0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; code = '0; code_valid = 1'b0;
      hsync = 1'b0; vsync = 1'b0; rfsh = 1'b0;
      tick(3);
      check("R1 video in reset", int'(video), 0);
      check("R1 addr in reset", int'(rom_addr), 0);
      rst_n = 1'b1;
      tick(1);
      check("R1 video after reset", int'(video), 0);
      cmp_en = 1'b1;

      cur_tag = "R9"; tick(5);
      cur_tag = "R6"; refresh(3); tick(12);
      check("R9 idle video", int'(video), 0);

      cur_tag = "R7"; fetch_char(8'h05); tick(12);
      cur_tag = "R8"; fetch_char(8'h85); tick(12);
      cur_tag = "R3"; fetch_char(8'h7F); tick(12);
      fetch_char(8'h3F); tick(12);

      cur_tag = "R6"; put_code(8'h12); tick(1); refresh(4); tick(2); refresh(2); tick(12);

      cur_tag = "R4";
      for (int r = 0; r < 10; r++) begin
         pulse_h();
         fetch_char(8'(r + 3));
         tick(10);
      end

      cur_tag = "R5";
      pulse_h(); pulse_h(); pulse_h();
      pulse_v(); fetch_char(8'h21); tick(10);
      pulse_h(); pulse_h();
      hsync = 1'b1; vsync = 1'b1; tick(1); hsync = 1'b0; vsync = 1'b0;
      fetch_char(8'hA2); tick(10);

      cur_tag = "R2";
      put_code(8'h0A); put_code(8'h8B); tick(1); refresh(2); tick(12);

      cur_tag = "R10";
      pulse_h();
      fetch_char(8'h11); fetch_char(8'h92); fetch_char(8'h13);
      fetch_char(8'h24); tick(40);
      check("R9 video after stream", int'(video), 0);

      finish_run();
   end
endmodule